// File: doc/BRIEF.md
# Key-Protected SRAM Erase Controller

This block holds a small register set on a simple register bus. It also runs one hardware sequencer that fills an on-chip SRAM with zeros, one word per clock. Software starts a wipe of the main (second) SRAM by setting a self-clearing trigger bit. The trigger only takes effect after a two-write key handshake on a write-only key register, and each successful handshake allows one start. An external request line starts a wipe of a separate accelerator SRAM through the same sequencer. The memory write port carries a select bit that tells the two memories apart.

The control/status register shows the trigger bit and two busy flags, one for each memory. The configuration register holds four set-only lock bits and a sticky parity error flag. Hardware sets the flag from an input pulse, and software clears it by writing 1. Reads are combinational from the registered state.

Top module: `sramclr_ctrl`

## Requirements
- R1: After reset, the control/status register (offset 0x18), the configuration register (offset 0x1C) and the key register (offset 0x24) all read 0, and `mem_we` is low.
- R2: Reserved bits read 0 and writes to them have no effect. The key register and unmapped offsets read 0.
- R3: Writing 0x000000CA to the key register and then 0x00000053 as the next key write unlocks the trigger. Any other value written to the key register locks it again, and a locked-out sequence must restart from 0xCA.
- R4: While locked, writing 1 to control bit 0 has no effect: no erase starts and bit 0 stays 0.
- R5: While unlocked and idle, writing 1 to control bit 0 starts a main-SRAM erase and uses up the unlock, so a second set needs a new key sequence. A control write with bit 0 = 0 keeps the unlock.
- R6: An erase drives `mem_we` high for exactly DEPTH cycles, with `mem_addr` going 0 to DEPTH-1 in order and `mem_wdata` at 0. The first write appears in the cycle after the accepted start. For a main erase `mem_sel`=0, control bits 0 and 1 read 1 throughout, and both clear by themselves at the end.
- R7: A pulse on `accel_req` while the sequencer is idle starts an erase with `mem_sel`=1. Control bit 8 reads 1 throughout, and bits 0 and 1 stay 0.
- R8: Start requests that arrive while the sequencer is busy are dropped. A software set refused this way keeps the unlock. When a software set and `accel_req` arrive in the same idle cycle, the main erase wins and the accelerator request is dropped.
- R9: Configuration bit 8 is set by a `parity_err` pulse. Writing 1 to it clears it, and writing 0 leaves it unchanged. A pulse in the same cycle as a clearing write leaves it set.
- R10: Configuration bits 3:0 are set by writing 1 and are cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| parity_err | input | 1 | Parity error pulse from the main SRAM |
| accel_req | input | 1 | Accelerator SRAM erase request pulse |
| mem_we | output | 1 | Erase write enable |
| mem_sel | output | 1 | Erase target: 0 main SRAM, 1 accelerator SRAM |
| mem_addr | output | $clog2(DEPTH) | Erase word address |
| mem_wdata | output | DATA_W | Erase write data (zero) |

## Verification
The bench goes after these cases:
- A key sequence broken by a wrong value. A design that let the second key through anyway would start an erase and put unexpected writes on the memory port.
- Reuse of an unlock. A design that did not use up the unlock would allow a second erase without a new key sequence.
- Start requests that collide with a running erase or with each other. A design that did not arbitrate correctly would restart the address count, change the memory select mid-erase, or lose a refused unlock.
- A parity pulse in the same cycle as a clearing write. A design that got this wrong would drop the flag.
- Lock bits written with 0 afterwards. A design that got this wrong would clear them.

// File: rtl/sramclr_pkg.sv
package sramclr_pkg;
   localparam int REG_AW = 8;
   localparam logic [REG_AW-1:0] OFS_CTRL = 8'h18;
   localparam logic [REG_AW-1:0] OFS_CFG  = 8'h1C;
   localparam logic [REG_AW-1:0] OFS_KEY  = 8'h24;
   localparam logic [31:0] KEY_FIRST  = 32'h0000_00CA;
   localparam logic [31:0] KEY_SECOND = 32'h0000_0053;
   localparam int LOCK_W    = 4;
   localparam int PAR_BIT   = 8;
   localparam int ACCEL_BIT = 8;

   typedef enum logic [1:0] {
      KEY_LOCKED = 2'd0,
      KEY_HALF   = 2'd1,
      KEY_OPEN   = 2'd2
   } key_state_e;

   typedef enum logic {
      TGT_MAIN  = 1'b0,
      TGT_ACCEL = 1'b1
   } tgt_e;
endpackage

// File: rtl/sramclr_keylock.sv
module sramclr_keylock
   import sramclr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_wr,
   input  logic [31:0] key_data,
   input  logic        consume,
   output logic        unlocked
);
   key_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (key_wr) begin
         unique case (state_q)
            KEY_LOCKED: state_d = (key_data == KEY_FIRST)  ? KEY_HALF : KEY_LOCKED;
            KEY_HALF:   state_d = (key_data == KEY_SECOND) ? KEY_OPEN : KEY_LOCKED;
            default:    state_d = (key_data == KEY_FIRST)  ? KEY_HALF : KEY_LOCKED;
         endcase
      end else if (consume) begin
         state_d = KEY_LOCKED;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KEY_LOCKED;
      else        state_q <= state_d;
   end

   assign unlocked = (state_q == KEY_OPEN);

   // R3: opening only follows a correct second key after the first
   a_r3_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && !$past(unlocked)) |->
         $past(key_wr && key_data == KEY_SECOND && state_q == KEY_HALF));

   // R5: an accepted start uses up the unlock
   a_r5_consume_relocks: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && !key_wr) |=> !unlocked);
endmodule

// File: rtl/sramclr_seq.sv
module sramclr_seq
   import sramclr_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  tgt_e                     start_tgt,
   output logic                     busy,
   output tgt_e                     tgt,
   output logic                     mem_we,
   output logic [$clog2(DEPTH)-1:0] mem_addr,
   output logic [DATA_W-1:0]        mem_wdata
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sramclr_seq: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("sramclr_seq: DATA_W must be at least 1");
      end
   endgenerate

   logic          busy_q;
   logic [AW-1:0] cnt_q;
   tgt_e          tgt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         tgt_q  <= TGT_MAIN;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            tgt_q  <= start_tgt;
         end
      end else if (cnt_q == LAST) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign busy      = busy_q;
   assign tgt       = tgt_q;
   assign mem_we    = busy_q;
   assign mem_addr  = cnt_q;
   assign mem_wdata = '0;

   // R6: the first write goes to address 0
   a_r6_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (mem_we && mem_addr == '0));
   // R6: addresses step by one while the erase runs
   a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr != LAST) |=> (mem_we && mem_addr == $past(mem_addr) + 1'b1));
   // R6: the write at the last address ends the erase
   a_r6_ends_at_last: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr == LAST) |=> !mem_we);
   // R8: the target cannot change during an erase
   a_r8_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(tgt));
endmodule

// File: rtl/sramclr_ctrl.sv
module sramclr_ctrl
   import sramclr_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [7:0]               reg_addr,
   input  logic                     reg_wr,
   input  logic [31:0]              reg_wdata,
   output logic [31:0]              reg_rdata,
   input  logic                     parity_err,
   input  logic                     accel_req,
   output logic                     mem_we,
   output logic                     mem_sel,
   output logic [$clog2(DEPTH)-1:0] mem_addr,
   output logic [DATA_W-1:0]        mem_wdata
);
   generate
      if (REG_AW != 8) begin : g_bad_regaw
         $error("sramclr_ctrl: register offset width must be 8");
      end
   endgenerate

   logic wr_ctrl, wr_cfg, wr_key;
   logic unlocked, sw_set, hw_start, seq_busy;
   logic main_busy, accel_busy;
   tgt_e seq_tgt;
   logic [LOCK_W-1:0] lock_q;
   logic              par_q;

   assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
   assign wr_cfg  = reg_wr && (reg_addr == OFS_CFG);
   assign wr_key  = reg_wr && (reg_addr == OFS_KEY);

   assign sw_set   = wr_ctrl && reg_wdata[0] && unlocked && !seq_busy;
   assign hw_start = accel_req && !seq_busy && !sw_set;

   sramclr_keylock u_keylock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (wr_key),
      .key_data (reg_wdata),
      .consume  (sw_set),
      .unlocked (unlocked)
   );

   sramclr_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (sw_set || hw_start),
      .start_tgt (sw_set ? TGT_MAIN : TGT_ACCEL),
      .busy      (seq_busy),
      .tgt       (seq_tgt),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   assign mem_sel    = (seq_tgt == TGT_ACCEL);
   assign main_busy  = seq_busy && (seq_tgt == TGT_MAIN);
   assign accel_busy = seq_busy && (seq_tgt == TGT_ACCEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= '0;
         par_q  <= 1'b0;
      end else begin
         if (wr_cfg) lock_q <= lock_q | reg_wdata[LOCK_W-1:0];
         if (parity_err)                       par_q <= 1'b1;
         else if (wr_cfg && reg_wdata[PAR_BIT]) par_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFS_CTRL: begin
            reg_rdata[0]         = main_busy;
            reg_rdata[1]         = main_busy;
            reg_rdata[ACCEL_BIT] = accel_busy;
         end
         OFS_CFG: begin
            reg_rdata[LOCK_W-1:0] = lock_q;
            reg_rdata[PAR_BIT]    = par_q;
         end
         default: reg_rdata = '0;
      endcase
   end

   // R9: a parity pulse always leaves the flag set
   a_r9_parity_wins: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err |=> par_q);
   // R9: writing 0 to the flag never clears it
   a_r9_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (par_q && !(wr_cfg && reg_wdata[PAR_BIT])) |=> par_q);
   // R10: lock bits never fall
   a_r10_locks_hold: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(lock_q) & ~lock_q) == '0));
   // R4: no main erase begins while locked
   a_r4_locked_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> !$rose(main_busy));
   // R8: a busy sequencer never switches target mid-run
   a_r8_busy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (accel_busy && !$past(accel_busy)) |-> !$past(seq_busy));
endmodule

// File: tb/sramclr_ctrl_bench.sv
module sramclr_ctrl_bench;
   localparam int PERIOD = 10;
   localparam int DEPTH  = 16;
   localparam int AW     = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] reg_addr = '0;
   logic reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic parity_err = 1'b0;
   logic accel_req = 1'b0;
   logic mem_we, mem_sel;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;

   int checks = 0;
   int errors = 0;
   int expq[$];

   always #(PERIOD/2) clk = ~clk;

   sramclr_ctrl #(.DEPTH(DEPTH), .DATA_W(32)) u_sramclr_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .parity_err(parity_err),
      .accel_req(accel_req), .mem_we(mem_we), .mem_sel(mem_sel),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver side of the scoreboard: one expected write per word
   task automatic expect_erase(input int sel);
      for (int i = 0; i < DEPTH; i++) expq.push_back(sel * 1000 + i);
   endtask

   // monitor side: every memory write must match the head of the queue
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         if (expq.size() == 0) begin
            chk("R4/R8 unexpected write", {mem_sel, 31'(mem_addr)}, 32'hFFFF_FFFF);
         end else begin
            chk("R6/R7 write order", 32'(int'(mem_sel) * 1000 + int'(mem_addr)),
                32'(expq.pop_front()));
            chk("R6 zero data", mem_wdata, 32'h0);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse_accel();
      @(negedge clk); accel_req = 1'b1;
      @(negedge clk); accel_req = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (DEPTH + 2) @(negedge clk);
   endtask

   task automatic unlock();
      wr(8'h24, 32'hCA);
      wr(8'h24, 32'h53);
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(8'h18, d); chk("R1 ctrl reset", d, 32'h0);
      rd(8'h1C, d); chk("R1 cfg reset", d, 32'h0);
      rd(8'h24, d); chk("R1 key reads zero", d, 32'h0);
      chk("R1 no write", {31'b0, mem_we}, 32'h0);
      // R4 locked set ignored
      wr(8'h18, 32'h1);
      rd(8'h18, d); chk("R4 locked set", d, 32'h0);
      repeat (4) @(negedge clk);
      // R10 set-only locks
      wr(8'h1C, 32'h5); rd(8'h1C, d); chk("R10 set", d, 32'h5);
      wr(8'h1C, 32'h2); rd(8'h1C, d); chk("R10 accumulate", d, 32'h7);
      wr(8'h1C, 32'h0); rd(8'h1C, d); chk("R10 zero keeps", d, 32'h7);
      // R2 reserved bits ignored
      wr(8'h1C, 32'hFFFF_FEF0); rd(8'h1C, d); chk("R2 cfg reserved", d, 32'h7);
      // R9 parity flag
      @(negedge clk); parity_err = 1'b1; @(negedge clk); parity_err = 1'b0;
      rd(8'h1C, d); chk("R9 set by pulse", d, 32'h107);
      wr(8'h1C, 32'h0); rd(8'h1C, d); chk("R9 write 0 keeps", d, 32'h107);
      wr(8'h1C, 32'h100); rd(8'h1C, d); chk("R9 write 1 clears", d, 32'h7);
      @(negedge clk);
      parity_err = 1'b1; reg_addr = 8'h1C; reg_wdata = 32'h100; reg_wr = 1'b1;
      @(negedge clk);
      parity_err = 1'b0; reg_wr = 1'b0;
      rd(8'h1C, d); chk("R9 pulse beats clear", d, 32'h107);
      wr(8'h1C, 32'h100);
      // R5/R6 main erase
      unlock();
      expect_erase(0);
      wr(8'h18, 32'h1);
      rd(8'h18, d); chk("R6 busy bits", d, 32'h3);
      wait_idle();
      rd(8'h18, d); chk("R6 self clear", d, 32'h0);
      chk("R6 all words written", 32'(expq.size()), 32'h0);
      wr(8'h18, 32'h1); repeat (3) @(negedge clk);
      rd(8'h18, d); chk("R5 unlock used up", d, 32'h0);
      // R3 broken sequence
      wr(8'h24, 32'hCA); wr(8'h24, 32'h11); wr(8'h24, 32'h53);
      wr(8'h18, 32'h1); repeat (3) @(negedge clk);
      rd(8'h18, d); chk("R3 broken key", d, 32'h0);
      // R7 accelerator erase
      expect_erase(1);
      pulse_accel();
      rd(8'h18, d); chk("R7 accel busy", d, 32'h100);
      // R8 refused set keeps the unlock
      unlock();
      wr(8'h18, 32'h1);
      rd(8'h18, d); chk("R8 set while busy", d, 32'h100);
      wait_idle();
      rd(8'h18, d); chk("R7 accel done", d, 32'h0);
      expect_erase(0);
      wr(8'h18, 32'h1);
      rd(8'h18, d); chk("R8 unlock kept", d, 32'h3);
      pulse_accel();
      wait_idle();
      chk("R8 accel during main dropped", 32'(expq.size()), 32'h0);
      // R8 simultaneous requests: main wins
      unlock();
      expect_erase(0);
      @(negedge clk);
      reg_addr = 8'h18; reg_wdata = 32'h1; reg_wr = 1'b1; accel_req = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; accel_req = 1'b0;
      rd(8'h18, d); chk("R8 main wins", d, 32'h3);
      wait_idle();
      // R2 reserved control bits, R5 zero write keeps unlock
      unlock();
      wr(8'h18, 32'hFFFF_FFFE); rd(8'h18, d); chk("R2 ctrl reserved", d, 32'h0);
      rd(8'h04, d); chk("R2 unmapped", d, 32'h0);
      rd(8'h24, d); chk("R2 key reads zero", d, 32'h0);
      expect_erase(0);
      wr(8'h18, 32'h1);
      rd(8'h18, d); chk("R5 zero write kept unlock", d, 32'h3);
      wait_idle();
      chk("R6 queue drained", 32'(expq.size()), 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule